// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a synchronous static RAM. It can take a new read, write or deselect command on every rising clock edge, with no idle cycles needed when traffic switches between reads and writes. The write data for a write command arrives on a later clock edge than its address. A read that comes in while an earlier write to the same address is still waiting for its data gets that write's bytes forwarded to it, so the host does not have to insert dead cycles.

A static mode input selects one of two timings. In pipelined mode, read data passes through an output register and write data follows its address by two edges. In flow-through mode, read data is driven straight from the array and write data follows by one edge. The block also has:
- per-lane write enables on 9-bit lanes;
- three chip enables;
- a four-beat burst counter with linear or interleaved order;
- an asynchronous output enable;
- a sleep input that freezes the device without losing its contents.

The array depth is a small parameter. The output bus `q` reads as zero whenever `q_drv` is low. `q_drv` stands in for the tri-state drive of a real pad.

Top module: `lw_sram`

## Requirements
- R1: A load command is accepted only when `en_a`=1, `en_b`=1 and `en_c_n`=0, with `adv`=0. With `adv`=0 and any other enable combination the cycle is a deselect: nothing is written, and the result slot shows `q_drv`=0.
- R2: With `pipe_mode`=0, a read accepted at clock edge k drives its word on `q` with `q_drv`=1 between edge k and edge k+1.
- R3: With `pipe_mode`=1, a read accepted at edge k drives its word between edge k+1 and edge k+2.
- R4: A write accepted at edge k takes its data from `wdata` at edge k+1 when `pipe_mode`=0, and at edge k+2 when `pipe_mode`=1.
- R5: Reads and writes may follow each other on consecutive edges in any order. Every read returns the contents produced by all writes accepted before it, including writes whose data has not yet been taken, forwarded lane by lane.
- R6: `be[i]`=1 writes bits [9i+8:9i] of the word. Lanes with `be[i]`=0 keep their old value. `be` is ignored on reads.
- R7: With `burst_ilv`=0, beat n of a burst (n=0..3) uses address bits [1:0] equal to (base[1:0]+n) mod 4. The upper bits stay those of the base.
- R8: With `burst_ilv`=1, beat n uses address bits [1:0] equal to base[1:0] XOR n.
- R9: `adv`=1 continues the active burst with the same operation and ignores the chip enables. The beat count wraps from 3 to 0. If no burst is active, `adv`=1 acts as a deselect.
- R10: `oe_n`=1 forces `q_drv`=0 in the same cycle, without waiting for a clock edge. `q` is all zeros whenever `q_drv`=0.
- R11: While `sleep`=1, new commands are ignored and any active burst ends. `q_drv` is forced to 0 asynchronously. The array contents are kept.
- R12: While `rst`=1 and after reset, `q_drv`=0 until a read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling is on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pipe_mode | input | 1 | 1 = pipelined timing, 0 = flow-through timing (static) |
| burst_ilv | input | 1 | 1 = interleaved burst order, 0 = linear (static) |
| sleep | input | 1 | Power-down: ignore commands, disable output |
| oe_n | input | 1 | Asynchronous output enable, active low |
| en_a | input | 1 | Chip enable, active high |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| adv | input | 1 | 1 = advance the active burst, 0 = load a new command |
| wr | input | 1 | On a load: 1 = write, 0 = read |
| addr | input | ADDR_W | Word address for a load |
| be | input | LANES | Per-lane write enables |
| wdata | input | LANES*LANE_W | Late write data |
| q | output | LANES*LANE_W | Read data; zero when not driven |
| q_drv | output | 1 | Output drive enable |

## Verification
The bench aims at four corner cases.

A read issued one edge after a partial write to the same address is the main target. If forwarding were missing, the read would return the stale word. If forwarding ignored the lanes, it would return the masked bytes of the write data. In pipelined mode this is visible only because the write data comes two edges late.

Bursts are run past the fourth beat with the chip enables deasserted. A wrong counter would leave the aligned group of four, use the wrong order, or drop the beats whose enables are inactive.

An `adv` after a deselect must produce nothing. A design that kept a stale burst alive would drive data here.

Commands given during sleep must leave the array unchanged. `oe_n` must blank a result in the very cycle it is raised. A design that registered `oe_n` would drive the data a cycle too long.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low two address bits of a burst beat, from the base and the beat count.
    function automatic logic [1:0] beat_low(input logic [1:0] base,
                                            input logic [1:0] cnt,
                                            input logic       ilv);
        return ilv ? (base ^ cnt) : (base + cnt);
    endfunction

endpackage

// File: rtl/lw_sram_cmd.sv
module lw_sram_cmd
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic              sel,
    input  logic              adv,
    input  logic              wr,
    input  logic              burst_ilv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [LANES-1:0]  s1_be,
    output op_e               s2_op,
    output logic [ADDR_W-1:0] s2_addr,
    output logic [LANES-1:0]  s2_be
);

    logic              burst_act;
    op_e               burst_op;
    logic [ADDR_W-1:0] burst_base;
    logic [1:0]        burst_cnt;
    logic              do_load;
    logic              do_step;
    logic [1:0]        cnt_nxt;

    always_comb begin
        do_load = !sleep && !adv && sel;
        do_step = !sleep && adv && burst_act;
        cnt_nxt = burst_cnt + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_act  <= 1'b0;
            burst_op   <= OP_NONE;
            burst_base <= '0;
            burst_cnt  <= '0;
            s1_op      <= OP_NONE;
            s1_addr    <= '0;
            s1_be      <= '0;
            s2_op      <= OP_NONE;
            s2_addr    <= '0;
            s2_be      <= '0;
        end else begin
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_be   <= s1_be;
            s1_be   <= be;
            if (do_load) begin
                burst_act  <= 1'b1;
                burst_op   <= wr ? OP_WRITE : OP_READ;
                burst_base <= addr;
                burst_cnt  <= 2'd0;
                s1_op      <= wr ? OP_WRITE : OP_READ;
                s1_addr    <= addr;
            end else if (do_step) begin
                burst_cnt <= cnt_nxt;
                s1_op     <= burst_op;
                s1_addr   <= {burst_base[ADDR_W-1:2],
                              beat_low(burst_base[1:0], cnt_nxt, burst_ilv)};
            end else begin
                burst_act <= 1'b0;
                s1_op     <= OP_NONE;
            end
        end
    end

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES-1:0]        wbe,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wbe[g]) begin
                cells[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
    end

endmodule

// File: rtl/lw_sram_rdpath.sv
module lw_sram_rdpath
    import lw_sram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pipe_mode,
    input  op_e                     s1_op,
    input  logic [LANES*LANE_W-1:0] arr_q,
    input  logic                    fwd_hit,
    input  logic [LANES-1:0]        fwd_be,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] out_q,
    output logic                    out_vld
);

    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] hold_q;
    logic              hold_vld;

    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign merged[g*LANE_W +: LANE_W] = (fwd_hit && fwd_be[g])
                                          ? wdata[g*LANE_W +: LANE_W]
                                          : arr_q[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            hold_vld <= 1'b0;
        end else begin
            hold_q   <= merged;
            hold_vld <= (s1_op == OP_READ);
        end
    end

    always_comb begin
        if (pipe_mode) begin
            out_q   = hold_q;
            out_vld = hold_vld;
        end else begin
            out_q   = arr_q;
            out_vld = (s1_op == OP_READ);
        end
    end

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pipe_mode,
    input  logic                    burst_ilv,
    input  logic                    sleep,
    input  logic                    oe_n,
    input  logic                    en_a,
    input  logic                    en_b,
    input  logic                    en_c_n,
    input  logic                    adv,
    input  logic                    wr,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        be,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] q,
    output logic                    q_drv
);

    localparam int DATA_W = LANES * LANE_W;

    op_e               s1_op, s2_op;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [LANES-1:0]  s1_be, s2_be;
    logic              sel;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;
    logic [LANES-1:0]  arr_wbe;
    logic [DATA_W-1:0] arr_q;
    logic              fwd_hit;
    logic [DATA_W-1:0] rd_q;
    logic              rd_vld;

    assign sel = en_a && en_b && !en_c_n;

    lw_sram_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
        .clk(clk), .rst(rst), .sleep(sleep), .sel(sel), .adv(adv), .wr(wr),
        .burst_ilv(burst_ilv), .addr(addr), .be(be),
        .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be),
        .s2_op(s2_op), .s2_addr(s2_addr), .s2_be(s2_be)
    );

    // Late write: commit from stage one (single late) or stage two (double late).
    always_comb begin
        if (pipe_mode) begin
            arr_we    = (s2_op == OP_WRITE);
            arr_waddr = s2_addr;
            arr_wbe   = s2_be;
        end else begin
            arr_we    = (s1_op == OP_WRITE);
            arr_waddr = s1_addr;
            arr_wbe   = s1_be;
        end
        fwd_hit = pipe_mode && (s2_op == OP_WRITE) && (s2_addr == s1_addr);
    end

    lw_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .we(arr_we), .waddr(arr_waddr), .wbe(arr_wbe),
        .wdata(wdata), .raddr(s1_addr), .rdata(arr_q)
    );

    lw_sram_rdpath #(.LANES(LANES), .LANE_W(LANE_W)) u_rd (
        .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .s1_op(s1_op),
        .arr_q(arr_q), .fwd_hit(fwd_hit), .fwd_be(s2_be), .wdata(wdata),
        .out_q(rd_q), .out_vld(rd_vld)
    );

    always_comb begin
        q_drv = rd_vld && !oe_n && !sleep;
        q     = q_drv ? rd_q : '0;
    end

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    pipe_mode,
    input logic                    sleep,
    input logic                    oe_n,
    input logic                    en_a,
    input logic                    en_b,
    input logic                    en_c_n,
    input logic                    adv,
    input logic                    wr,
    input logic [LANES*LANE_W-1:0] q,
    input logic                    q_drv
);

    // R10
    oe_blank_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !q_drv);

    // R11
    sleep_blank_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !q_drv);

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !q_drv |-> (q == '0));

    // R1
    flow_desel_chk: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && !adv && !(en_a && en_b && !en_c_n)) |=> !q_drv);

    // R1
    pipe_desel_chk: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && !adv && !(en_a && en_b && !en_c_n)) |=> ##1 !q_drv);

    // R4
    flow_wr_nodrive_chk: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && !adv && wr) |=> !q_drv);

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !q_drv);

endmodule

bind lw_sram lw_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .sleep(sleep), .oe_n(oe_n),
    .en_a(en_a), .en_b(en_b), .en_c_n(en_c_n), .adv(adv), .wr(wr),
    .q(q), .q_drv(q_drv)
);

// File: tb/lw_sram_test.sv
module lw_sram_test;

    localparam int AW = 6;
    localparam int L  = 4;
    localparam int LW = 9;
    localparam int DW = L * LW;
    localparam int K_RD  = 0;
    localparam int K_WR  = 1;
    localparam int K_ADV = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pipe_mode = 1'b0, burst_ilv = 1'b0, sleep = 1'b0, oe_n = 1'b0;
    logic          en_a = 1'b0, en_b = 1'b0, en_c_n = 1'b1, adv = 1'b0, wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [L-1:0]  be = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] q;
    logic          q_drv;

    always #4 clk = ~clk;

    lw_sram #(.ADDR_W(AW), .LANES(L), .LANE_W(LW)) uut (
        .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv),
        .sleep(sleep), .oe_n(oe_n), .en_a(en_a), .en_b(en_b), .en_c_n(en_c_n),
        .adv(adv), .wr(wr), .addr(addr), .be(be), .wdata(wdata),
        .q(q), .q_drv(q_drv)
    );

    typedef struct {
        int            due;
        bit            drv;
        logic [DW-1:0] d;
        string         req;
    } exp_t;

    exp_t          sbq[$];
    logic [DW-1:0] model [0:(1<<AW)-1];
    bit            off_log [int];
    logic [DW-1:0] wsched [int];
    int            cyc = 0;
    int            checks = 0;
    int            errors = 0;
    bit            done = 0;
    bit            pm, il;
    bit            b_act, b_wr;
    logic [AW-1:0] b_base;
    logic [1:0]    b_cnt;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old,
                                                 input logic [DW-1:0] nw,
                                                 input logic [L-1:0] m);
        logic [DW-1:0] r = old;
        for (int i = 0; i < L; i++)
            if (m[i]) r[i*LW +: LW] = nw[i*LW +: LW];
        return r;
    endfunction

    // Driver: one command slot; pushes the expected result into the scoreboard.
    task automatic step(input int kind, input logic [AW-1:0] a, input logic [L-1:0] b,
                        input logic [DW-1:0] d, input string req,
                        input logic [2:0] ens = 3'b110, input bit oe_off = 0,
                        input bit slp = 0);
        int            slot;
        logic [AW-1:0] ea;
        bit            isrd, iswr;
        exp_t          e;
        @(posedge clk);
        #2;
        slot   = cyc + 1;
        en_a   = ens[2];
        en_b   = ens[1];
        en_c_n = ens[0];
        adv    = (kind == K_ADV);
        wr     = (kind == K_WR);
        addr   = a;
        be     = b;
        oe_n   = oe_off;
        sleep  = slp;
        wdata  = wsched.exists(slot) ? wsched[slot] : {$urandom, $urandom};
        off_log[slot-1] = oe_off | slp;
        isrd = 0;
        iswr = 0;
        ea   = a;
        if (slp) begin
            b_act = 0;
        end else if (kind == K_ADV && b_act) begin
            b_cnt = b_cnt + 2'd1;
            ea    = {b_base[AW-1:2], il ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
            isrd  = !b_wr;
            iswr  = b_wr;
        end else if (kind != K_ADV && ens == 3'b110) begin
            b_act  = 1;
            b_wr   = (kind == K_WR);
            b_base = a;
            b_cnt  = 0;
            isrd   = (kind == K_RD);
            iswr   = (kind == K_WR);
        end else begin
            b_act = 0;
        end
        e.due = slot + (pm ? 1 : 0);
        e.drv = isrd;
        e.d   = isrd ? model[ea] : '0;
        e.req = req;
        sbq.push_back(e);
        if (iswr) begin
            wsched[slot + (pm ? 2 : 1)] = d;
            model[ea] = lane_merge(model[ea], d, b);
        end
    endtask

    // Monitor: compares every due result away from the clock edge.
    always @(negedge clk) begin
        if (!rst && sbq.size() > 0 && sbq[0].due == cyc) begin
            exp_t e;
            bit   edrv;
            e    = sbq.pop_front();
            edrv = e.drv && !(off_log.exists(cyc) && off_log[cyc]);
            chk(q_drv == edrv, e.req, {35'b0, q_drv}, {35'b0, edrv});
            if (edrv) chk(q == e.d, e.req, q, e.d);
            else      chk(q == '0, {e.req, "/R10"}, q, '0);
        end
    end

    task automatic do_reset(input bit p, input bit i);
        @(posedge clk);
        #2;
        rst = 1; pipe_mode = p; burst_ilv = i; pm = p; il = i;
        en_a = 0; en_b = 0; en_c_n = 1; adv = 0; oe_n = 0; sleep = 0;
        sbq.delete();
        b_act = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: no drive while in reset
        chk(q_drv == 1'b0, "R12", {35'b0, q_drv}, '0);
        @(posedge clk);
        #2;
        rst = 0;
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) step(K_RD, 0, 0, 0, "R1", 3'b000);
    endtask

    task automatic suite(input bit p, input bit i);
        string rlat, rbur;
        rlat = p ? "R3" : "R2";
        rbur = i ? "R8" : "R7";
        do_reset(p, i);
        // R12: first results after reset are idle
        drain();
        // R4: fill the array, then read it back (R2 / R3)
        for (int a = 0; a < 16; a++)
            step(K_WR, a[AW-1:0], 4'hF, {4'(a), 32'hA5C3_0000 + 32'(a * 77) + 32'({p, i})}, "R4");
        for (int a = 0; a < 16; a++)
            step(K_RD, a[AW-1:0], 4'h0, 0, rlat);
        // R5 / R6: partial write followed at once by reads of the same word
        step(K_WR, 5, 4'b0101, 36'hF_1234_5678, "R6");
        step(K_RD, 5, 4'hF, 0, "R5");
        step(K_RD, 5, 4'h0, 0, "R5");
        step(K_WR, 6, 4'hF, 36'h1_1111_1111, "R5");
        step(K_WR, 6, 4'b1000, 36'h9_8765_4321, "R6");
        step(K_RD, 6, 4'h0, 0, "R5");
        step(K_RD, 4, 4'h0, 0, "R5");
        step(K_WR, 7, 4'b0010, 36'h2_2222_2222, "R6");
        step(K_RD, 7, 4'h0, 0, "R6");
        // R1: each enable alone deselects
        step(K_RD, 3, 0, 0, "R1", 3'b010);
        step(K_RD, 3, 0, 0, "R1", 3'b100);
        step(K_RD, 3, 0, 0, "R1", 3'b111);
        step(K_WR, 3, 4'hF, 36'h0_DEAD_BEEF, "R1", 3'b000);
        step(K_RD, 3, 0, 0, "R1");
        // R7 / R8 / R9: burst write with enables off during advance
        step(K_WR, 10, 4'hF, 36'h3_0000_000A, rbur);
        step(K_ADV, 0, 4'hF, 36'h3_0000_000B, "R9", 3'b000);
        step(K_ADV, 0, 4'b0011, 36'h3_0000_000C, "R9", 3'b000);
        step(K_ADV, 0, 4'hF, 36'h3_0000_000D, "R9", 3'b000);
        for (int a = 8; a < 12; a++) step(K_RD, a[AW-1:0], 0, 0, rbur);
        // Burst read that wraps past the fourth beat
        step(K_RD, 9, 0, 0, rbur);
        for (int n = 0; n < 5; n++) step(K_ADV, 0, 0, 0, "R9", 3'b000);
        // R9: advance with no active burst does nothing
        step(K_RD, 0, 0, 0, "R9", 3'b000);
        step(K_ADV, 0, 0, 0, "R9");
        step(K_ADV, 0, 0, 0, "R9");
        // R10: output enable blanks results in the same cycle
        step(K_RD, 1, 0, 0, "R10");
        step(K_RD, 2, 0, 0, "R10", 3'b110, 1);
        step(K_RD, 3, 0, 0, "R10", 3'b110, 1);
        step(K_RD, 4, 0, 0, "R10");
        step(K_RD, 5, 0, 0, "R10");
        drain();
        // R11: sleep ignores commands and keeps contents
        step(K_WR, 0, 4'hF, 36'h0_BAD0_BAD0, "R11", 3'b110, 0, 1);
        step(K_RD, 0, 0, 0, "R11", 3'b110, 0, 1);
        step(K_WR, 1, 4'hF, 36'h0_BAD1_BAD1, "R11", 3'b110, 0, 1);
        step(K_ADV, 0, 0, 0, "R11");
        step(K_RD, 0, 0, 0, "R11");
        step(K_RD, 1, 0, 0, "R11");
        drain();
    endtask

    initial begin
        for (int a = 0; a < (1 << AW); a++) model[a] = 'x;
        suite(0, 0);
        suite(1, 0);
        suite(0, 1);
        suite(1, 1);
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule